// File: doc/BRIEF.md
# Handshaked Sequential Logical Shifter

This block is a small multi-cycle shifter meant to sit as the arithmetic engine behind a computation unit. A producer offers an operand, a shift amount and a direction bit on a valid/ready input port. The block takes them in one transfer. It then moves the operand one bit position per clock under the control of a small state machine. When the work is done, it offers the result on a separate valid/ready output port.

Only logical shifts are supported, in both directions, and vacated bit positions are filled with zeros. The shift amount is clamped to the data width, so any amount at or above the width gives an all-zero result in a bounded number of cycles. The result is held on the output until the consumer takes it. The block accepts no new operand until that has happened.

Top module: `seq_shifter`

## Requirements
- R1: While reset is held and right after it, in_ready is 1, out_valid is 0 and out_data is 0.
- R2: in_ready is 1 only when the block is idle. A transfer happens on a clock edge where in_valid and in_ready are both 1, and it captures in_data, in_amount and in_dir_right. Changes to those inputs after the transfer do not alter the result.
- R3: With in_dir_right = 1 the result is a logical right shift with zero fill. For example, 13 shifted by 2 gives 3, and 0x80 shifted by 7 gives 0x01.
- R4: With in_dir_right = 0 the result is a logical left shift with zero fill, truncated to 8 bits. For example, 3 shifted by 4 gives 48, and 0xFF shifted by 1 gives 0xFE.
- R5: A shift amount of 0 returns the operand unchanged in either direction.
- R6: A shift amount of 8 or more gives a result of 0 in either direction.
- R7: Call the transfer edge edge 0. out_valid first reads 1 right after edge min(amount, 8). For amount 0, that is the transfer edge itself.
- R8: Once out_valid is 1, it stays 1 and out_data stays stable until an edge sees out_ready = 1. After that edge, out_valid is 0 and in_ready is 1.
- R9: out_data reads 0 whenever out_valid is 0.
- R10: Assertions of in_valid while the block is busy (shifting or holding a result) are not accepted. They leave the pending result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers an operand |
| in_ready | output | 1 | Block is idle and can take an operand |
| in_data | input | 8 | Operand to shift |
| in_amount | input | 8 | Number of bit positions to shift |
| in_dir_right | input | 1 | 1 = logical right, 0 = logical left |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 8 | Shifted result, 0 when out_valid is 0 |

## Verification
The shift is tried in both directions with amounts 0, 1, 2, 4, 7, 8 and a large value. Amount 0 separates the direct-to-done path from the shifting path. Amount 7 exposes an off-by-one in the step count, and amounts of 8 and above check the clamp. Operands with bits at both edges (0x80, 0xFF, 0x01) tell a logical shift from a rotate or an arithmetic shift. Scrambling the inputs after the transfer, and offering a second operand while busy, tell a captured operand from a live one. Holding out_ready low for several cycles shows that the result is held.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } shf_state_e;
endpackage

// File: rtl/shf_counter.sv
module shf_counter #(
  parameter int DATA_W = 8,
  parameter int AMT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [AMT_W-1:0] amt_in,
  output logic             load_is_zero,
  output logic             cnt_last
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  // clamp: any amount at or above the width costs exactly DATA_W steps
  function automatic logic [CNT_W-1:0] clamp_amt(input logic [AMT_W-1:0] a);
    if (32'(a) >= 32'(DATA_W)) return CNT_W'(DATA_W);
    return CNT_W'(a);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= clamp_amt(amt_in);
    else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign load_is_zero = (clamp_amt(amt_in) == '0);
  assign cnt_last     = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/shf_datapath.sv
module shf_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              show,
  input  logic [DATA_W-1:0] din,
  input  logic              dir_right_in,
  output logic [DATA_W-1:0] dout
);
  // one logical bit position, zero fill on the vacated side
  function automatic logic [DATA_W-1:0] shift_one(input logic [DATA_W-1:0] v,
                                                  input logic right);
    if (right) return {1'b0, v[DATA_W-1:1]};
    return {v[DATA_W-2:0], 1'b0};
  endfunction

  logic [DATA_W-1:0] val_q;
  logic              dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
      dir_q <= 1'b0;
    end else if (load) begin
      val_q <= din;
      dir_q <= dir_right_in;
    end else if (step) begin
      val_q <= shift_one(val_q, dir_q);
    end
  end

  assign dout = show ? val_q : '0;
endmodule

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       out_ready,
  input  logic       load_is_zero,
  input  logic       cnt_last,
  output logic       idle,
  output logic       busy_shift,
  output logic       done,
  output logic       accept,
  output logic       finish,
  output logic       release_res
);
  shf_state_e st_q, st_d;

  assign idle        = (st_q == ST_IDLE);
  assign busy_shift  = (st_q == ST_SHIFT);
  assign done        = (st_q == ST_DONE);
  assign accept      = idle && in_valid;
  assign finish      = (busy_shift && cnt_last) || (accept && load_is_zero);
  assign release_res = done && out_ready;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = load_is_zero ? ST_DONE : ST_SHIFT;
      ST_SHIFT: if (cnt_last) st_d = ST_DONE;
      ST_DONE:  if (out_ready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/seq_shifter.sv
module seq_shifter #(
  parameter int DATA_W = 8,
  parameter int AMT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [AMT_W-1:0]  in_amount,
  input  logic              in_dir_right,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  // named internal events, visible to the bound checker
  logic accept_evt;
  logic step_evt;
  logic finish_evt;
  logic release_evt;
  logic load_is_zero;
  logic cnt_last;
  logic idle_w;
  logic done_w;

  shf_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_ready    (out_ready),
    .load_is_zero (load_is_zero),
    .cnt_last     (cnt_last),
    .idle         (idle_w),
    .busy_shift   (step_evt),
    .done         (done_w),
    .accept       (accept_evt),
    .finish       (finish_evt),
    .release_res  (release_evt)
  );

  shf_counter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept_evt),
    .dec          (step_evt),
    .amt_in       (in_amount),
    .load_is_zero (load_is_zero),
    .cnt_last     (cnt_last)
  );

  shf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept_evt),
    .step         (step_evt),
    .show         (done_w),
    .din          (in_data),
    .dir_right_in (in_dir_right),
    .dout         (out_data)
  );

  assign in_ready  = idle_w;
  assign out_valid = done_w;
endmodule

// File: rtl/seq_shifter_chk.sv
module seq_shifter_chk #(
  parameter int DATA_W = 8,
  parameter int AMT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [AMT_W-1:0]  in_amount,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              accept_evt,
  input logic              step_evt,
  input logic              finish_evt,
  input logic              release_evt
);
  int unsigned elapsed;
  int unsigned want_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed  <= 0;
      want_lat <= 0;
    end else if (in_valid && in_ready) begin
      elapsed  <= 0;
      want_lat <= (32'(in_amount) < 32'(DATA_W)) ? 32'(in_amount) : 32'(DATA_W);
    end else if (!in_ready && !out_valid) begin
      elapsed <= elapsed + 1;
    end
  end

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({in_ready, step_evt, out_valid}) == 1); // R2
  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !in_ready); // R2
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> !accept_evt); // R10
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (elapsed == want_lat)); // R7
  AST_FINISH_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> out_valid); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (in_ready && !out_valid)); // R8
  AST_ZERO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0)); // R9
endmodule

bind seq_shifter seq_shifter_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_amount   (in_amount),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .accept_evt  (accept_evt),
  .step_evt    (step_evt),
  .finish_evt  (finish_evt),
  .release_evt (release_evt)
);

// File: tb/tb_seq_shifter.sv
`timescale 1ns/1ps
module tb_seq_shifter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [7:0] in_amount = 8'h00;
  logic       in_dir_right = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  seq_shifter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_amount(in_amount), .in_dir_right(in_dir_right),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // reference: multiply / divide by a power of two, then truncate
  function automatic int ref_shift(int d, int a, bit right);
    if (a >= 8) return 0;
    if (right) return d / (1 << a);
    return (d * (1 << a)) % 256;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 in_ready in reset", int'(in_ready), 1);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 out_data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 in_ready after reset", int'(in_ready), 1);
    check("R1 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_op(string req, int d, int a, bit right, int hold);
    int lat;
    int exp;
    int held;
    exp = ref_shift(d, a, right);
    @(negedge clk);
    check({req, " R2 ready before offer"}, int'(in_ready), 1);
    in_valid = 1'b1; in_data = 8'(d); in_amount = 8'(a); in_dir_right = right;
    @(negedge clk);
    // R2: scramble inputs after the transfer
    in_valid = 1'b0; in_data = ~8'(d); in_amount = 8'd3; in_dir_right = ~right;
    lat = 0;
    while (!out_valid && lat < 20) begin
      check({req, " R9 data zero while busy"}, int'(out_data), 0);
      @(negedge clk);
      lat++;
    end
    check({req, " R7 latency"}, lat, (a < 8) ? a : 8);
    check({req, " result"}, int'(out_data), exp);
    held = int'(out_data);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check({req, " R8 valid held"}, int'(out_valid), 1);
      check({req, " R8 data stable"}, int'(out_data), held);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check({req, " R8 valid drops"}, int'(out_valid), 0);
    check({req, " R8 ready returns"}, int'(in_ready), 1);
    check({req, " R9 data zero after"}, int'(out_data), 0);
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'hB4; in_amount = 8'd5; in_dir_right = 1'b1;
    @(negedge clk);
    // keep offering a different operand while busy
    in_data = 8'h0F; in_amount = 8'd0; in_dir_right = 1'b0;
    lat = 0;
    while (!out_valid && lat < 20) begin
      check("R10 R2 not ready while busy", int'(in_ready), 0);
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    check("R10 R2 not ready while holding", int'(in_ready), 0);
    in_valid = 1'b0;
    check("R10 result of first operand", int'(out_data), ref_shift(8'hB4, 5, 1'b1));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R10 back to idle", int'(in_ready), 1);
    check("R10 no second result", int'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_op("R3 13>>2", 13, 2, 1'b1, 2);
    t_op("R4 3<<4", 3, 4, 1'b0, 0);
    t_op("R5 amount 0 left", 21, 0, 1'b0, 1);
    t_op("R5 amount 0 right", 8'hA5, 0, 1'b1, 0);
    t_op("R3 0x80>>7", 8'h80, 7, 1'b1, 0);
    t_op("R4 0xFF<<1", 8'hFF, 1, 1'b0, 3);
    t_op("R4 0x01<<7", 8'h01, 7, 1'b0, 0);
    t_op("R6 amount 8 left", 8'hFF, 8, 1'b0, 0);
    t_op("R6 amount 200 right", 8'hFF, 200, 1'b1, 1);
    t_busy_ignore();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule